// File: doc/BRIEF.md
# Seven-Level Inverter Predictive State Selector

This block chooses, once per control sample, which of the eight switching states a six-switch packed U-cell inverter should apply next. It works by finite-control-set model predictive control. When a start strobe arrives, it captures a fixed-point snapshot of the grid current, the grid voltage, the reference current, both DC-link voltages and both MPPT target voltages. It then spends one clock on each candidate state. For each state it forms the inverter output voltage, predicts the grid current one sample ahead with a first-order RL model, and scores the state with a weighted quadratic cost. The cheapest state wins. It is presented on six complementary gate outputs together with a one-cycle done pulse.

All analog quantities share one signed integer scale, so one LSB of current and one LSB of voltage are in matching units. The model coefficients, computed for R = 0.1 Ω, L = 2.5 mH and a 20 µs sample, are parameters held with 16 fractional bits. The reference generator, phase tracking, MPPT search, converter front end and dead-time insertion all sit outside this block.

Top module: `fcs_state_selector`

## Requirements
- R1: States 1 to 8 are reported on `state_o` as codes 0 to 7. Their (Sa,Sb,Sc) triples are 100, 101, 110, 111, 000, 001, 010, 011. The gate word carries Sa, Sb and Sc in bits 0, 1 and 2.
- R2: Each candidate's inverter voltage is (Sa−Sb)·V1 + (Sb−Sc)·V2. With V1 = 3·V2 = 3E the states give +3E, +2E, +E, 0, 0, −E, −2E and −3E in state order.
- R3: The predicted current is floor((A·i + B·(Vin − vs)) / 2^16), where A = 65484 (1 − R·Ts/L) and B = 524 (Ts/L).
- R4: The cost is 10·(i_pred − i_ref)² + 5·(V1 − Vtrk1)² + 5·(V2 − Vtrk2)².
- R5: The state with the lowest cost is selected. On equal cost the lower-numbered state wins, so an ideal zero-voltage match picks state 4 (code 3) over state 5.
- R6: Gate bits 3, 4 and 5 are always the inverses of bits 0, 1 and 2.
- R7: A start sampled while idle produces exactly one done pulse, one cycle wide, 8 clock edges after the sampling edge. A start that arrives during an evaluation is ignored.
- R8: `gate_o` and `state_o` change only in the cycle where `done_o` is high. The result depends only on the inputs captured at the start edge.
- R9: The cost saturates at 2^32−1 instead of wrapping. When every candidate saturates, the tie rule selects state 1.
- R10: After reset `state_o` is 4 (state 5), `gate_o` is 6'b111000 and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe; the inputs are captured on this edge |
| i_meas_i | input | 16 | Measured grid current, signed |
| v_grid_i | input | 16 | Grid voltage, signed |
| i_ref_i | input | 16 | Reference grid current, signed |
| v_dc1_i | input | 16 | Main DC-link voltage, signed |
| v_dc2_i | input | 16 | Auxiliary DC-link voltage, signed |
| v_trk1_i | input | 16 | MPPT target for the main link, signed |
| v_trk2_i | input | 16 | MPPT target for the auxiliary link, signed |
| gate_o | output | 6 | Gates Sa, Sb, Sc, Sd, Se, Sf in bits 0 to 5 |
| state_o | output | 3 | Applied state minus one |
| done_o | output | 1 | One-cycle pulse when a new state is applied |

## Verification
The bench builds the block with its defaults: 16-bit samples, 16 fractional coefficient bits and a 32-bit cost. With a 32-bit cost, DC-link errors near 30000 LSB push every candidate into saturation, so the clamp becomes observable within ordinary input ranges. With the ±3000-LSB link voltages used in the level sweep, the predictions for the seven levels differ by whole LSBs, so each level, and the tie between the two zero states, can be selected by choosing the reference current alone.

// File: rtl/fcs_pkg.sv
// Shared constants and helpers for the predictive state selector.
// Assumes the fixed eight-state packed U-cell topology.
package fcs_pkg;

    localparam int NCAND = 8;
    localparam int IW    = 3;

    // Switch triple {Sa,Sb,Sc} of candidate code idx (state idx+1).
    function automatic logic [2:0] cand_abc(input logic [IW-1:0] idx);
        return {~idx[2], idx[1], idx[0]};
    endfunction

    // Six-bit gate word: [0]=Sa [1]=Sb [2]=Sc [3]=Sd [4]=Se [5]=Sf.
    function automatic logic [5:0] gate_word(input logic [IW-1:0] idx);
        logic [2:0] abc;
        abc = cand_abc(idx);
        return {~abc[0], ~abc[1], ~abc[2], abc[0], abc[1], abc[2]};
    endfunction

endpackage

// File: rtl/fcs_candidate_map.sv
// Maps a candidate code to its signed DC-link coefficient pair.
// S1 = Sa - Sb weights V1, S2 = Sb - Sc weights V2; both lie in {-1,0,+1}.
module fcs_candidate_map
    import fcs_pkg::*;
(
    input  logic [IW-1:0]      idx,
    output logic signed [1:0]  s1,
    output logic signed [1:0]  s2
);
    logic [2:0] abc;

    // Derive the coefficient pair from the switch triple.
    always_comb begin
        abc = cand_abc(idx);
        s1  = $signed({1'b0, abc[2]}) - $signed({1'b0, abc[1]});
        s2  = $signed({1'b0, abc[1]}) - $signed({1'b0, abc[0]});
    end
endmodule

// File: rtl/fcs_predictor.sv
// One-step grid current predictor for a single candidate.
// Vin = s1*V1 + s2*V2; ipred = floor((A*i + B*(Vin - vs)) / 2^FRAC).
// Assumes current and voltage share one LSB scale and that A and B are
// non-negative constants below 2^(FRAC+1).
module fcs_predictor #(
    parameter int DW      = 16,
    parameter int FRAC    = 16,
    parameter int PDW     = DW + 5,
    parameter int COEF_A  = 65484,
    parameter int COEF_B  = 524
) (
    input  logic signed [1:0]      s1,
    input  logic signed [1:0]      s2,
    input  logic signed [DW-1:0]   v1,
    input  logic signed [DW-1:0]   v2,
    input  logic signed [DW-1:0]   vs,
    input  logic signed [DW-1:0]   ik,
    output logic signed [PDW-1:0]  ipred
);
    localparam int VW = DW + 2;
    localparam int PW = FRAC + PDW;
    localparam logic signed [PW-1:0] CA = PW'(COEF_A);
    localparam logic signed [PW-1:0] CB = PW'(COEF_B);

    logic signed [VW-1:0] t1, t2, vin;
    logic signed [PW-1:0] vin_x, vs_x, ik_x, diff, sum;

    // Select +V, -V or zero for each link term.
    always_comb begin
        case (s1)
            2'b01:   t1 = {{2{v1[DW-1]}}, v1};
            2'b11:   t1 = -{{2{v1[DW-1]}}, v1};
            default: t1 = '0;
        endcase
        case (s2)
            2'b01:   t2 = {{2{v2[DW-1]}}, v2};
            2'b11:   t2 = -{{2{v2[DW-1]}}, v2};
            default: t2 = '0;
        endcase
        vin = t1 + t2;
    end

    // Form the fixed-point prediction and drop the fractional bits.
    always_comb begin
        vin_x = {{(PW-VW){vin[VW-1]}}, vin};
        vs_x  = {{(PW-DW){vs[DW-1]}}, vs};
        ik_x  = {{(PW-DW){ik[DW-1]}}, ik};
        diff  = vin_x - vs_x;
        sum   = CA * ik_x + CB * diff;
        ipred = PDW'(sum >>> FRAC);
    end
endmodule

// File: rtl/fcs_cost.sv
// Weighted quadratic cost of one candidate, clamped to CW bits.
// cost = WI*(ipred-iref)^2 + WV1*(v1-t1)^2 + WV2*(v2-t2)^2.
// Assumes non-negative weights below 256.
module fcs_cost #(
    parameter int DW  = 16,
    parameter int PDW = DW + 5,
    parameter int CW  = 32,
    parameter int WI  = 10,
    parameter int WV1 = 5,
    parameter int WV2 = 5
) (
    input  logic signed [PDW-1:0] ipred,
    input  logic signed [DW-1:0]  iref,
    input  logic signed [DW-1:0]  v1,
    input  logic signed [DW-1:0]  trk1,
    input  logic signed [DW-1:0]  v2,
    input  logic signed [DW-1:0]  trk2,
    output logic [CW-1:0]         cost
);
    localparam int SW = 2 * (PDW + 1) + 10;

    logic signed [SW-1:0] ei, e1, e2;
    logic [SW-1:0]        sq_i, sq_1, sq_2, total;

    // Signed errors, widened so their squares cannot overflow.
    always_comb begin
        ei = {{(SW-PDW){ipred[PDW-1]}}, ipred} - {{(SW-DW){iref[DW-1]}}, iref};
        e1 = {{(SW-DW){v1[DW-1]}}, v1} - {{(SW-DW){trk1[DW-1]}}, trk1};
        e2 = {{(SW-DW){v2[DW-1]}}, v2} - {{(SW-DW){trk2[DW-1]}}, trk2};
        sq_i = ei * ei;
        sq_1 = e1 * e1;
        sq_2 = e2 * e2;
        total = SW'(WI) * sq_i + SW'(WV1) * sq_1 + SW'(WV2) * sq_2;
    end

    // Clamp to the largest CW-bit value when the exact sum is too wide.
    generate
        if (SW > CW) begin : g_clamp
            localparam logic [SW-1:0] CMAX = {{(SW-CW){1'b0}}, {CW{1'b1}}};
            always_comb cost = (total > CMAX) ? {CW{1'b1}} : total[CW-1:0];
        end else begin : g_pass
            always_comb cost = CW'(total);
        end
    endgenerate
endmodule

// File: rtl/fcs_state_selector.sv
// Predictive switching-state selector for a seven-level packed U-cell.
// A start strobe while idle captures all samples; the next eight cycles
// score candidates 0..7 one per cycle; the winner is applied together
// with a one-cycle done pulse. Starts during a search are ignored.
// Assumes one shared LSB scale for all currents and voltages.
module fcs_state_selector
    import fcs_pkg::*;
#(
    parameter int DW     = 16,
    parameter int FRAC   = 16,
    parameter int COEF_A = 65484,
    parameter int COEF_B = 524,
    parameter int CW     = 32,
    parameter int WI     = 10,
    parameter int WV1    = 5,
    parameter int WV2    = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic signed [DW-1:0]  i_meas_i,
    input  logic signed [DW-1:0]  v_grid_i,
    input  logic signed [DW-1:0]  i_ref_i,
    input  logic signed [DW-1:0]  v_dc1_i,
    input  logic signed [DW-1:0]  v_dc2_i,
    input  logic signed [DW-1:0]  v_trk1_i,
    input  logic signed [DW-1:0]  v_trk2_i,
    output logic [5:0]            gate_o,
    output logic [2:0]            state_o,
    output logic                  done_o
);
    localparam int PDW = DW + 5;
    localparam logic [IW-1:0] LAST_IDX = IW'(NCAND - 1);
    localparam logic [IW-1:0] ZERO_LOW = IW'(4);

    logic signed [DW-1:0] cap_i, cap_vs, cap_ref, cap_v1, cap_v2, cap_t1, cap_t2;
    logic                 busy;
    logic [IW-1:0]        idx, best_idx, win_idx;
    logic [CW-1:0]        best_cost, cost;
    logic signed [1:0]    s1, s2;
    logic signed [PDW-1:0] ipred;
    logic                 take;

    fcs_candidate_map u_map (
        .idx (idx),
        .s1  (s1),
        .s2  (s2)
    );

    fcs_predictor #(
        .DW(DW), .FRAC(FRAC), .PDW(PDW), .COEF_A(COEF_A), .COEF_B(COEF_B)
    ) u_pred (
        .s1    (s1),
        .s2    (s2),
        .v1    (cap_v1),
        .v2    (cap_v2),
        .vs    (cap_vs),
        .ik    (cap_i),
        .ipred (ipred)
    );

    fcs_cost #(
        .DW(DW), .PDW(PDW), .CW(CW), .WI(WI), .WV1(WV1), .WV2(WV2)
    ) u_cost (
        .ipred (ipred),
        .iref  (cap_ref),
        .v1    (cap_v1),
        .trk1  (cap_t1),
        .v2    (cap_v2),
        .trk2  (cap_t2),
        .cost  (cost)
    );

    // Current candidate replaces the best on the first step or strictly lower cost.
    always_comb begin
        take    = (idx == '0) || (cost < best_cost);
        win_idx = take ? idx : best_idx;
    end

    // Capture the sample snapshot on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_i   <= '0;
            cap_vs  <= '0;
            cap_ref <= '0;
            cap_v1  <= '0;
            cap_v2  <= '0;
            cap_t1  <= '0;
            cap_t2  <= '0;
        end else if (!busy && start_i) begin
            cap_i   <= i_meas_i;
            cap_vs  <= v_grid_i;
            cap_ref <= i_ref_i;
            cap_v1  <= v_dc1_i;
            cap_v2  <= v_dc2_i;
            cap_t1  <= v_trk1_i;
            cap_t2  <= v_trk2_i;
        end
    end

    // Sequence the candidate index and the busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (!busy) begin
            if (start_i) begin
                busy <= 1'b1;
                idx  <= '0;
            end
        end else begin
            idx <= idx + 1'b1;
            if (idx == LAST_IDX) begin
                busy <= 1'b0;
            end
        end
    end

    // Track the running minimum across the search.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_cost <= '0;
            best_idx  <= '0;
        end else if (busy && take) begin
            best_cost <= cost;
            best_idx  <= idx;
        end
    end

    // Apply the winner and pulse done after the last candidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o  <= 1'b0;
            state_o <= ZERO_LOW;
            gate_o  <= gate_word(ZERO_LOW);
        end else begin
            done_o <= 1'b0;
            if (busy && idx == LAST_IDX) begin
                done_o  <= 1'b1;
                state_o <= win_idx;
                gate_o  <= gate_word(win_idx);
            end
        end
    end
endmodule

// File: rtl/fcs_selector_checker.sv
// Property checker for the predictive state selector, bound to its top.
// Tracks accepted starts with its own counter to check the done timing.
module fcs_selector_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [5:0] gate_o,
    input logic [2:0] state_o,
    input logic       done_o
);
    logic       act;
    logic [2:0] cnt;

    // Shadow count of cycles since an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act <= 1'b0;
            cnt <= '0;
        end else if (!act) begin
            if (start_i) begin
                act <= 1'b1;
                cnt <= '0;
            end
        end else if (cnt == 3'd7) begin
            act <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_GATE_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n) gate_o[5:3] == ~gate_o[2:0]); // R6
    AST_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done_o |-> ($stable(gate_o) && $stable(state_o))); // R8
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) (act && cnt == 3'd7) |=> done_o); // R7
    AST_DONE_ONLY_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> $past(act && cnt == 3'd7)); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R7
endmodule

bind fcs_state_selector fcs_selector_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .gate_o  (gate_o),
    .state_o (state_o),
    .done_o  (done_o)
);

// File: tb/tb_fcs_state_selector.sv
module tb_fcs_state_selector;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic signed [15:0] im = 0, vg = 0, ir = 0, v1 = 0, v2 = 0, t1 = 0, t2 = 0;
    logic [5:0] gate;
    logic [2:0] st;
    logic done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    localparam longint CA  = 65484;
    localparam longint CB  = 524;
    localparam longint SAT = 64'h0000_0000_FFFF_FFFF;

    fcs_state_selector dut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .i_meas_i(im), .v_grid_i(vg), .i_ref_i(ir),
        .v_dc1_i(v1), .v_dc2_i(v2), .v_trk1_i(t1), .v_trk2_i(t2),
        .gate_o(gate), .state_o(st), .done_o(done)
    );

    always #10 clk = ~clk;

    // Level of state code k from the switch triple in R1 and the sum in R2.
    function automatic longint level(int k, longint a, longint b);
        int sa, sb, sc;
        sa = (k < 4) ? 1 : 0;
        sb = (k / 2) % 2;
        sc = k % 2;
        return (sa - sb) * a + (sb - sc) * b;
    endfunction

    // R3 prediction.
    function automatic longint pred(longint i, longint vs, longint vin);
        return (CA * i + CB * (vin - vs)) >>> 16;
    endfunction

    // R4 / R5 / R9 selection.
    function automatic int pick(longint i, longint vs, longint r, longint a,
                                longint b, longint p, longint q);
        longint best, c, e;
        int w;
        best = 0;
        w = 0;
        for (int k = 0; k < 8; k++) begin
            e = pred(i, vs, level(k, a, b)) - r;
            c = 10 * e * e + 5 * (a - p) * (a - p) + 5 * (b - q) * (b - q);
            if (c > SAT) c = SAT;
            if (k == 0 || c < best) begin
                best = c;
                w = k;
            end
        end
        return w;
    endfunction

    function automatic logic [5:0] gates_of(int k);
        logic sa, sb, sc;
        sa = (k < 4);
        sb = ((k / 2) % 2) == 1;
        sc = (k % 2) == 1;
        return {~sc, ~sb, ~sa, sc, sb, sa};
    endfunction

    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural model updated on each rising edge.
    bit m_busy = 0;
    int m_cnt = 0;
    bit m_done = 0;
    int m_state = 4;
    int m_pend = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_done = 0; m_state = 4;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == 8) begin
                    m_busy = 0;
                    m_done = 1;
                    m_state = m_pend;
                end
            end else if (start) begin
                m_pend = pick(im, vg, ir, v1, v2, t1, t2);
                m_busy = 1;
                m_cnt = 0;
            end
        end
    end

    // Compare every cycle away from the active edge (R7, R8).
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(done === m_done, "R7 done timing", done, m_done);
            check(st === 3'(m_state), "R8 state per cycle", st, m_state);
            check(gate === gates_of(m_state), "R8 gates per cycle", gate, gates_of(m_state));
        end
    end

    task automatic set_in(int a, int b, int r, int d1, int d2, int p, int q);
        im = 16'(a); vg = 16'(b); ir = 16'(r);
        v1 = 16'(d1); v2 = 16'(d2); t1 = 16'(p); t2 = 16'(q);
    endtask

    // Pulse start, wait for done, return the applied state code.
    task automatic run(output int res);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int n = 0; n < 20 && !done; n++) @(negedge clk);
        res = st;
        check(gate[5:3] == ~gate[2:0], "R6 complementary gates", gate, {~gate[2:0], gate[2:0]});
        check(gate == gates_of(res), "R1 gate pattern", gate, gates_of(res));
    endtask

    task automatic summary;
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int res, exp, dn, first;
        repeat (5) @(negedge clk);
        check(st == 3'd4, "R10 reset state", st, 4);
        check(gate == 6'b111000, "R10 reset gates", gate, 6'b111000);
        check(done == 1'b0, "R10 reset done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Seven levels with V1 = 3*V2; the zero level ties states 4 and 5.
        for (int k = 0; k < 8; k++) begin
            if (k == 4) continue;
            set_in(0, 0, int'(pred(0, 0, level(k, 3000, 1000))), 3000, 1000, 3000, 1000);
            run(res);
            check(res == k, (k == 3) ? "R5 zero tie keeps state 4" : "R2 level selection", res, k);
        end

        // Nonzero current and grid voltage.
        set_in(2000, 500, 1990, 3000, 1000, 3000, 1000);
        run(res);
        exp = pick(2000, 500, 1990, 3000, 1000, 3000, 1000);
        check(res == exp, "R3 prediction with i and vs", res, exp);

        // Saturated costs: all equal, state 1 wins.
        set_in(0, 0, -24, 3000, 1000, -27000, -29000);
        run(res);
        check(res == 0, "R9 saturated cost", res, 0);

        // Start during evaluation and input changes are ignored.
        set_in(0, 0, -24, 3000, 1000, 3000, 1000);
        first = pick(0, 0, -24, 3000, 1000, 3000, 1000);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        set_in(0, 0, 23, 3000, 1000, 3000, 1000);
        @(negedge clk);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        dn = 0;
        res = -1;
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            if (done) begin
                dn++;
                res = st;
            end
        end
        check(dn == 1, "R7 start while busy ignored", dn, 1);
        check(res == first, "R8 captured inputs used", res, first);

        // Mixed patterns against the model.
        for (int n = 0; n < 40; n++) begin
            int a, b, r, d2, p, q;
            a = $urandom_range(6000) - 3000;
            b = $urandom_range(6000) - 3000;
            d2 = $urandom_range(2500) + 500;
            r = $urandom_range(400) - 200 + a;
            p = 3 * d2 + $urandom_range(40) - 20;
            q = d2 + $urandom_range(40) - 20;
            set_in(a, b, r, 3 * d2, d2, p, q);
            run(res);
            exp = pick(a, b, r, 3 * d2, d2, p, q);
            check(res == exp, "R4 minimum cost choice", res, exp);
        end

        repeat (3) @(negedge clk);
        summary();
    end
endmodule